// File: doc/BRIEF.md
# Paired Fractional Multiply and Round Unit

This block is a small arithmetic datapath for packed signed fractional data. Each 32-bit source word carries two 16-bit fractions (one sign bit and fifteen fraction bits). In multiply mode the unit forms two lane products. For each lane it doubles the signed product and rounds it to the nearest value by adding half an output LSB. It then keeps the upper half. The one operand pair whose true product is +1.0, and so cannot be represented, is clamped to the largest positive fraction.

In reduce mode the unit treats each source as one 32-bit fraction. It rounds each source down to 16 bits, clamps the few positive values that would wrap, and packs the two results into one word. Either kind of clamp raises a dedicated sticky bit in a flag register. Software reads the flag register and clears it by writing zero.

A caller presents both sources, the mode and a valid strobe in one cycle. The packed result and its valid strobe appear on the registered outputs one cycle later.

Top module: `pq15_rnd_unit`

## Requirements
- R1: With `mode_sel` = 0 (multiply), each output lane is bits [31:16] of (2 × signed product of the matching input lanes + 0x0000_8000). The upper output lane comes from the upper halves of `src_a` and `src_b`, and the lower lane comes from the lower halves. Example: 0x80011234 with 0x80024321 gives 0x7FFD098C.
- R2: In multiply mode, a lane whose two operands are both 0x8000 yields 0x7FFF and sets flag bit 21 of `ovf_flags`. The other lane is computed normally.
- R3: In multiply mode, a lane with only one operand at 0x8000 is not clamped and does not set any flag. 0x8000 × 0x8001 yields 0x7FFF with bit 21 clear.
- R4: With `mode_sel` = 1 (reduce), each result is bits [31:16] of (source + 0x8000). The result from `src_a` goes to bits [31:16] and the result from `src_b` goes to bits [15:0].
- R5: In reduce mode, a source that is signed-greater than 0x7FFF7FFF yields 0x7FFF and sets flag bit 22. A source of exactly 0x7FFF7FFF yields 0x7FFF with no flag.
- R6: In reduce mode, negative sources are never clamped. 0x80000000 yields 0x8000, 0xFFFF8000 yields 0x0000 and 0xFFFF7FFF yields 0xFFFF, all without a flag.
- R7: The same source pair gives results that depend on `mode_sel`. 0x80011234 with 0x80024321 gives 0x7FFD098C in multiply mode and 0x80018002 in reduce mode.
- R8: `res_valid` is high exactly in the cycle after a cycle with `in_valid` high. `res_out` keeps its last value, and no flag is raised, while `in_valid` is low.
- R9: Flag bits 21 and 22 are sticky. They stay set across later non-clamping operations until software writes them.
- R10: When `ctl_we` is high, the flag register loads bits 21 and 22 of `ctl_wdata`, so writing zero clears them. An overflow in the same cycle still sets its bit. All other bits of `ovf_flags` read zero.
- R11: After reset, `res_out` is 0, `res_valid` is 0 and `ovf_flags` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sources and mode are valid this cycle |
| mode_sel | input | 1 | 0 = lane multiply, 1 = word reduce and pack |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| ctl_we | input | 1 | Write strobe for the flag register |
| ctl_wdata | input | 32 | Value written to the flag register |
| res_valid | output | 1 | Result valid, one cycle after in_valid |
| res_out | output | 32 | Packed 2 × 16-bit result |
| ovf_flags | output | 32 | Sticky flag register (bit 21 multiply clamp, bit 22 reduce clamp) |

## Verification
The case hardest to reach from the ports is a clamping operation in the same cycle as a software write of zero to the flag register. The write must not hide the new overflow. The bench produces it by asserting `ctl_we` in the same cycle as a 0x8000 × 0x8000 multiply. The threshold edges of reduce mode are also driven deliberately with sources one apart: 0x7FFF7FFF does not clamp, 0x7FFF8000 does, and 0xFFFF8000 rounds to exactly zero. These edges separate a correct threshold from an off-by-one compare.

// File: rtl/pq15_pkg.sv
package pq15_pkg;
   typedef enum logic {
      MODE_MUL = 1'b0,
      MODE_RED = 1'b1
   } pq15_mode_e;
endpackage

// File: rtl/pq15_mul_lane.sv
module pq15_mul_lane #(
   parameter int LANE_W = 16
) (
   input  logic [LANE_W-1:0] op_x,
   input  logic [LANE_W-1:0] op_y,
   output logic [LANE_W-1:0] lane_res,
   output logic              lane_sat
);
   localparam int PROD_W = 2 * LANE_W;
   localparam logic [LANE_W-1:0] MOST_NEG = {1'b1, {(LANE_W-1){1'b0}}};
   localparam logic [LANE_W-1:0] MOST_POS = {1'b0, {(LANE_W-1){1'b1}}};
   localparam logic [PROD_W-1:0] HALF_LSB = PROD_W'(1) << (LANE_W - 1);

   logic signed [PROD_W-1:0] prod;
   logic        [PROD_W-1:0] rounded;

   always_comb begin
      prod     = $signed(op_x) * $signed(op_y);
      rounded  = (PROD_W'(prod) << 1) + HALF_LSB;
      lane_sat = (op_x == MOST_NEG) && (op_y == MOST_NEG);
      lane_res = lane_sat ? MOST_POS : LANE_W'(rounded >> LANE_W);
   end
endmodule

// File: rtl/pq15_red_lane.sv
module pq15_red_lane #(
   parameter int LANE_W = 16
) (
   input  logic [2*LANE_W-1:0] word_in,
   output logic [LANE_W-1:0]   lane_res,
   output logic                lane_sat
);
   localparam int WORD_W = 2 * LANE_W;
   localparam logic [LANE_W-1:0] MOST_POS = {1'b0, {(LANE_W-1){1'b1}}};
   localparam logic [WORD_W-1:0] CLAMP_THR = {MOST_POS, MOST_POS} & ~(WORD_W'(1) << (LANE_W - 1));
   localparam logic [WORD_W:0]   HALF_LSB = (WORD_W+1)'(1) << (LANE_W - 1);

   logic [WORD_W:0] sum;

   always_comb begin
      sum      = {word_in[WORD_W-1], word_in} + HALF_LSB;
      lane_sat = $signed(word_in) > $signed(CLAMP_THR);
      lane_res = lane_sat ? MOST_POS : LANE_W'(sum >> LANE_W);
   end
endmodule

// File: rtl/pq15_flag_reg.sv
module pq15_flag_reg #(
   parameter int CTRL_W  = 32,
   parameter int MUL_BIT = 21,
   parameter int RED_BIT = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_mul,
   input  logic              set_red,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output logic [CTRL_W-1:0] flags
);
   localparam logic [CTRL_W-1:0] MUL_MASK  = CTRL_W'(1) << MUL_BIT;
   localparam logic [CTRL_W-1:0] RED_MASK  = CTRL_W'(1) << RED_BIT;
   localparam logic [CTRL_W-1:0] FLAG_MASK = MUL_MASK | RED_MASK;

   logic [CTRL_W-1:0] base;
   logic [CTRL_W-1:0] raise;

   always_comb begin
      base  = wr_en ? (wr_data & FLAG_MASK) : flags;
      raise = (set_mul ? MUL_MASK : '0) | (set_red ? RED_MASK : '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= base | raise;
   end

   // R9: without a write, a set flag bit never drops
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ((flags & $past(flags)) == $past(flags)));
   // R10: bits outside the two flags always read zero
   a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((flags & ~FLAG_MASK) == '0));
endmodule

// File: rtl/pq15_rnd_unit.sv
module pq15_rnd_unit
   import pq15_pkg::*;
#(
   parameter int LANE_W  = 16,
   parameter int CTRL_W  = 32,
   parameter int MUL_BIT = 21,
   parameter int RED_BIT = 22
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  mode_sel,
   input  logic [2*LANE_W-1:0]   src_a,
   input  logic [2*LANE_W-1:0]   src_b,
   input  logic                  ctl_we,
   input  logic [CTRL_W-1:0]     ctl_wdata,
   output logic                  res_valid,
   output logic [2*LANE_W-1:0]   res_out,
   output logic [CTRL_W-1:0]     ovf_flags
);
   localparam int WORD_W = 2 * LANE_W;
   localparam int LANES  = 2;
   localparam logic [LANE_W-1:0] MOST_NEG = {1'b1, {(LANE_W-1){1'b0}}};
   localparam logic [LANE_W-1:0] MOST_POS = {1'b0, {(LANE_W-1){1'b1}}};

   generate
      if (LANE_W < 4) begin : g_bad_lane
         $error("LANE_W must be at least 4");
      end
      if (MUL_BIT >= CTRL_W || RED_BIT >= CTRL_W || MUL_BIT == RED_BIT) begin : g_bad_bits
         $error("flag bit positions must be distinct and inside CTRL_W");
      end
   endgenerate

   pq15_mode_e        mode;
   logic [WORD_W-1:0] mul_word;
   logic [WORD_W-1:0] red_word;
   logic [LANES-1:0]  mul_sat;
   logic [LANES-1:0]  red_sat;

   assign mode = pq15_mode_e'(mode_sel);

   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_lane
         pq15_mul_lane #(.LANE_W(LANE_W)) u_mul (
            .op_x     (src_a[gi*LANE_W +: LANE_W]),
            .op_y     (src_b[gi*LANE_W +: LANE_W]),
            .lane_res (mul_word[gi*LANE_W +: LANE_W]),
            .lane_sat (mul_sat[gi])
         );
         pq15_red_lane #(.LANE_W(LANE_W)) u_red (
            .word_in  ((gi == LANES-1) ? src_a : src_b),
            .lane_res (red_word[gi*LANE_W +: LANE_W]),
            .lane_sat (red_sat[gi])
         );
      end
   endgenerate

   logic set_mul;
   logic set_red;
   assign set_mul = in_valid && (mode == MODE_MUL) && (|mul_sat);
   assign set_red = in_valid && (mode == MODE_RED) && (|red_sat);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_out   <= '0;
      end else begin
         res_valid <= in_valid;
         if (in_valid) res_out <= (mode == MODE_RED) ? red_word : mul_word;
      end
   end

   pq15_flag_reg #(.CTRL_W(CTRL_W), .MUL_BIT(MUL_BIT), .RED_BIT(RED_BIT)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_mul (set_mul),
      .set_red (set_red),
      .wr_en   (ctl_we),
      .wr_data (ctl_wdata),
      .flags   (ovf_flags)
   );

   // R8: result strobe follows the input strobe by one cycle
   a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);
   a_r8_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!res_valid && $stable(res_out)));
   // R2: both upper operands at the most negative value clamp and flag
   a_r2_mul_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mode_sel && src_a[WORD_W-1 -: LANE_W] == MOST_NEG
       && src_b[WORD_W-1 -: LANE_W] == MOST_NEG)
      |=> (res_out[WORD_W-1 -: LANE_W] == MOST_POS && ovf_flags[MUL_BIT]));
   // R5: reduce mode clamps a large positive first source and flags it
   a_r5_red_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_sel && !src_a[WORD_W-1]
       && src_a[WORD_W-2 -: LANE_W-1] == MOST_POS[LANE_W-2:0] && src_a[LANE_W-1])
      |=> (res_out[WORD_W-1 -: LANE_W] == MOST_POS && ovf_flags[RED_BIT]));
   // R6: reduce mode never raises the multiply flag
   a_r6_red_no_mul_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel && !ctl_we && !ovf_flags[MUL_BIT]) |=> !ovf_flags[MUL_BIT]);
   // R3: multiply mode never raises the reduce flag
   a_r3_mul_no_red_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_sel && !ctl_we && !ovf_flags[RED_BIT]) |=> !ovf_flags[RED_BIT]);
endmodule

// File: tb/sim_pq15_rnd_unit.sv
module sim_pq15_rnd_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        mode_sel = 1'b0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic        ctl_we = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic        res_valid;
   logic [31:0] res_out;
   logic [31:0] ovf_flags;

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [31:0] F_MUL = 32'h0020_0000;
   localparam logic [31:0] F_RED = 32'h0040_0000;

   always #4 clk = ~clk;

   pq15_rnd_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_sel(mode_sel),
      .src_a(src_a), .src_b(src_b), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .res_valid(res_valid), .res_out(res_out), .ovf_flags(ovf_flags)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle of stimulus; outputs are sampled at the following falling edge
   task automatic step(input logic v, input logic m, input logic [31:0] a,
                       input logic [31:0] b, input logic we, input logic [31:0] wd);
      @(negedge clk);
      in_valid = v; mode_sel = m; src_a = a; src_b = b; ctl_we = we; ctl_wdata = wd;
      @(negedge clk);
      in_valid = 1'b0; ctl_we = 1'b0;
   endtask

   task automatic clear_flags();
      step(1'b0, 1'b0, '0, '0, 1'b1, 32'h0);
   endtask

   task automatic t_reset();
      check("R11 res_out", res_out, 32'h0);
      check("R11 res_valid", {31'h0, res_valid}, 32'h0);
      check("R11 flags", ovf_flags, 32'h0);
   endtask

   task automatic t_mul_basic();
      step(1'b1, 1'b0, 32'h8001_1234, 32'h8002_4321, 1'b0, '0);
      check("R1 example", res_out, 32'h7FFD_098C);
      check("R1 valid", {31'h0, res_valid}, 32'h1);
      check("R1 no flag", ovf_flags, 32'h0);
      step(1'b1, 1'b0, 32'h4000_4000, 32'h4000_C000, 1'b0, '0);
      check("R1 half squared/signed", res_out, 32'h2000_E000);
      step(1'b1, 1'b0, 32'hFFFF_0080, 32'h0001_0080, 1'b0, '0);
      check("R1 rounding", res_out, 32'h0000_0001);
   endtask

   task automatic t_mul_clamp();
      step(1'b1, 1'b0, 32'h8000_0000, 32'h8000_0000, 1'b0, '0);
      check("R2 upper clamp", res_out, 32'h7FFF_0000);
      check("R2 flag", ovf_flags, F_MUL);
      clear_flags();
      check("R10 clear", ovf_flags, 32'h0);
      step(1'b1, 1'b0, 32'h1234_8000, 32'h0001_8000, 1'b0, '0);
      check("R2 lower clamp", res_out, 32'h0000_7FFF);
      check("R2 lower flag", ovf_flags, F_MUL);
      clear_flags();
      step(1'b1, 1'b0, 32'h8000_8000, 32'h8001_8001, 1'b0, '0);
      check("R3 one operand", res_out, 32'h7FFF_7FFF);
      check("R3 no flag", ovf_flags, 32'h0);
   endtask

   task automatic t_reduce();
      step(1'b1, 1'b1, 32'h7FFF_C678, 32'h8654_32A0, 1'b0, '0);
      check("R4/R5 pack clamp", res_out, 32'h7FFF_8654);
      check("R5 flag", ovf_flags, F_RED);
      clear_flags();
      step(1'b1, 1'b1, 32'hBEEF_FEED, 32'h7FFF_8000, 1'b0, '0);
      check("R4 order", res_out, 32'hBEF0_7FFF);
      check("R5 threshold+1 flag", ovf_flags, F_RED);
      clear_flags();
      step(1'b1, 1'b1, 32'h7FFF_7FFF, 32'h8000_0000, 1'b0, '0);
      check("R5 at threshold", res_out, 32'h7FFF_8000);
      check("R5/R6 no flag", ovf_flags, 32'h0);
      step(1'b1, 1'b1, 32'hFFFF_8000, 32'hFFFF_7FFF, 1'b0, '0);
      check("R6 negative round", res_out, 32'h0000_FFFF);
      check("R6 no flag", ovf_flags, 32'h0);
   endtask

   task automatic t_mode();
      step(1'b1, 1'b1, 32'h8001_1234, 32'h8002_4321, 1'b0, '0);
      check("R7 reduce", res_out, 32'h8001_8002);
      step(1'b1, 1'b0, 32'h8001_1234, 32'h8002_4321, 1'b0, '0);
      check("R7 multiply", res_out, 32'h7FFD_098C);
   endtask

   task automatic t_idle();
      step(1'b0, 1'b0, 32'h8000_8000, 32'h8000_8000, 1'b0, '0);
      check("R8 idle valid", {31'h0, res_valid}, 32'h0);
      check("R8 idle hold", res_out, 32'h7FFD_098C);
      check("R8 idle no flag", ovf_flags, 32'h0);
   endtask

   task automatic t_sticky();
      step(1'b1, 1'b0, 32'h8000_0000, 32'h8000_0000, 1'b0, '0);
      step(1'b1, 1'b0, 32'h0001_0001, 32'h0001_0001, 1'b0, '0);
      step(1'b1, 1'b1, 32'h0000_0000, 32'h0000_0000, 1'b0, '0);
      check("R9 sticky", ovf_flags, F_MUL);
      step(1'b0, 1'b0, '0, '0, 1'b1, 32'hFFFF_FFFF);
      check("R10 write ones", ovf_flags, F_MUL | F_RED);
      step(1'b1, 1'b0, 32'h8000_0000, 32'h8000_0000, 1'b1, 32'h0);
      check("R10 write vs overflow", ovf_flags, F_MUL);
      clear_flags();
      check("R10 cleared", ovf_flags, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_mul_basic();
      t_mul_clamp();
      t_reduce();
      t_mode();
      t_idle();
      t_sticky();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #800000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule